// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Encoder

This block gathers the interrupt sources of a UART and reduces them to one interrupt line and one encoded status byte. Each source passes through its own bit of an 8-bit enable word. Among the enabled sources that are pending, only the one with the highest priority is reported. A source of lower priority stays pending but hidden until every source above it has been serviced.

Some sources are levels held by their producers: received data available and modem status change. Others are single-cycle event pulses that the block keeps in sticky flags: line status error, receive time-out and special character match. Each sticky flag stays set until its service strobe clears it. Transmit-holding-empty is tracked internally. Its flag is set at reset and again on every rising edge of the holding-empty level. A write to the holding register clears it, and so does a status read while it is the reported source.

Host software reads the status byte when the interrupt line rises, services the reported source, and reads again. The host bus and the logic that produces each source stay outside the block.

Top module: `isr_encoder`

## Requirements
- R1: After reset the transmit-empty flag is set. With enable bit 1 set, `irq_o` is 1 and `isr_o` is 0x02 straight away. With all enable bits clear, `isr_o` is 0x01 and `irq_o` is 0.
- R2: The enable bits are mapped as follows: bit 0 receive (ready and time-out), bit 1 transmit-empty, bit 2 line status error, bit 3 modem status, bit 4 special character. A pending source whose bit is clear has no effect on the outputs. Bits 7:5 are ignored.
- R3: Priority runs from highest to lowest: line status error (0x06), receive, special character (0x10), transmit-empty (0x02), modem status (0x00). Only the highest enabled pending source is reported.
- R4: Receive ready (0x04) and receive time-out (0x0C) share one priority level under enable bit 0. When both are pending, the time-out code is shown.
- R5: `isr_o[0]` is 0 exactly when `irq_o` is 1. When nothing enabled is pending, `isr_o` is 0x01.
- R6: A status read (`isr_rd_i`) clears the transmit-empty flag only when transmit-empty is the reported source.
- R7: A rising edge on `thr_empty_i` sets the transmit-empty flag. A holding-register write (`thr_wr_i`) clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: A line-status read (`lsr_rd_i`) clears the line error flag. A data read (`rhr_rd_i`) clears the time-out flag. A set event in the same cycle wins over either clear.
- R9: A special character match is reported as status bit 4 with bits 3:0 equal to 0. A status read clears it only while it is the reported source.
- R10: A hidden lower-priority source keeps its pending state. It appears in the cycle after the last higher source is cleared.
- R11: Every sticky flag changes on the clock edge that follows its strobe. The code change is visible in that same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_ready_i | input | 1 | Level: received data available |
| rx_timeout_evt_i | input | 1 | Pulse: receive time-out occurred |
| thr_empty_i | input | 1 | Level: transmit holding register empty |
| line_err_evt_i | input | 1 | Pulse: line status error occurred |
| spec_char_evt_i | input | 1 | Pulse: special character matched |
| modem_chg_i | input | 1 | Level: modem status change pending |
| ier_i | input | 8 | Interrupt enable word |
| isr_rd_i | input | 1 | Strobe: status byte read |
| lsr_rd_i | input | 1 | Strobe: line status read |
| thr_wr_i | input | 1 | Strobe: holding register write |
| rhr_rd_i | input | 1 | Strobe: receive data read |
| irq_o | output | 1 | Interrupt request, active high |
| isr_o | output | 8 | Encoded status of the highest pending source |

## Verification
The assertions check on every cycle that the interrupt line agrees with status bit 0 and that the receive codes appear only under enable bit 0 with the matching level. They also check that the special-character code always has a clear low nibble, that an enabled line-error pulse shows up one cycle later, and that the clearing strobes remove the transmit-empty code. Only the bench scenarios can show the full priority ordering across all combinations of pending sources and enable words. They also cover the reset-time transmit interrupt, and how hidden sources survive a status read and surface once the sources above them are serviced.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int IER_W  = 8;
  localparam int NSRC   = 6;
  localparam int SRC_IW = $clog2(NSRC);

  // enable bit positions
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;
  localparam int EN_SC = 4;

  // priority slots, 0 is highest
  typedef enum logic [SRC_IW-1:0] {
    SLOT_LS  = 3'd0,
    SLOT_TMO = 3'd1,
    SLOT_RDY = 3'd2,
    SLOT_SC  = 3'd3,
    SLOT_TX  = 3'd4,
    SLOT_MS  = 3'd5
  } slot_e;

  localparam logic [7:0] CODE_NONE = 8'h01;
  localparam logic [7:0] CODE_LS   = 8'h06;
  localparam logic [7:0] CODE_TMO  = 8'h0C;
  localparam logic [7:0] CODE_RDY  = 8'h04;
  localparam logic [7:0] CODE_SC   = 8'h10;
  localparam logic [7:0] CODE_TX   = 8'h02;
  localparam logic [7:0] CODE_MS   = 8'h00;

  function automatic logic [7:0] slot_code(input logic [NSRC-1:0] grant);
    logic [7:0] c;
    c = CODE_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) begin
        case (slot_e'(i))
          SLOT_LS:  c = CODE_LS;
          SLOT_TMO: c = CODE_TMO;
          SLOT_RDY: c = CODE_RDY;
          SLOT_SC:  c = CODE_SC;
          SLOT_TX:  c = CODE_TX;
          default:  c = CODE_MS;
        endcase
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/isr_rst_sync.sv
module isr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/isr_sticky.sv
module isr_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic q_en;

  // set has precedence over clear
  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= RST_VAL;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/isr_rise_det.sv
module isr_rise_det #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/isr_prio_enc.sv
module isr_prio_enc #(
  parameter int N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic [N:0] taken;

  // index 0 wins; each slot is granted only if nothing above requested
  assign taken[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_slot
    assign grant_o[g]  = req_i[g] & ~taken[g];
    assign taken[g+1]  = taken[g] | req_i[g];
  end
  assign any_o = taken[N];
endmodule

// File: rtl/isr_encoder.sv
module isr_encoder
  import isr_pkg::*;
#(
  parameter int EN_W = IER_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_ready_i,
  input  logic            rx_timeout_evt_i,
  input  logic            thr_empty_i,
  input  logic            line_err_evt_i,
  input  logic            spec_char_evt_i,
  input  logic            modem_chg_i,
  input  logic [EN_W-1:0] ier_i,
  input  logic            isr_rd_i,
  input  logic            lsr_rd_i,
  input  logic            thr_wr_i,
  input  logic            rhr_rd_i,
  output logic            irq_o,
  output logic [7:0]      isr_o
);
  logic rst_sync_n;
  logic ls_pend, tmo_pend, sc_pend, tx_pend;
  logic tx_rise;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  logic any_req;
  logic sc_clr, tx_clr;
  logic unused_ier_hi;

  assign unused_ier_hi = ^ier_i[EN_W-1:EN_SC+1];

  isr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  isr_rise_det #(.RST_VAL(1'b1)) u_tx_rise (
    .clk(clk), .rst_n(rst_sync_n), .lvl_i(thr_empty_i), .rise_o(tx_rise)
  );

  // status-read clears act only on the source currently reported
  always_comb begin
    sc_clr = isr_rd_i & grant[SLOT_SC];
    tx_clr = thr_wr_i | (isr_rd_i & grant[SLOT_TX]);
  end

  isr_sticky #(.RST_VAL(1'b0)) u_ls (
    .clk(clk), .rst_n(rst_sync_n), .set_i(line_err_evt_i), .clr_i(lsr_rd_i), .q_o(ls_pend)
  );
  isr_sticky #(.RST_VAL(1'b0)) u_tmo (
    .clk(clk), .rst_n(rst_sync_n), .set_i(rx_timeout_evt_i), .clr_i(rhr_rd_i), .q_o(tmo_pend)
  );
  isr_sticky #(.RST_VAL(1'b0)) u_sc (
    .clk(clk), .rst_n(rst_sync_n), .set_i(spec_char_evt_i), .clr_i(sc_clr), .q_o(sc_pend)
  );
  isr_sticky #(.RST_VAL(1'b1)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .set_i(tx_rise), .clr_i(tx_clr), .q_o(tx_pend)
  );

  always_comb begin
    req            = '0;
    req[SLOT_LS]   = ls_pend     & ier_i[EN_LS];
    req[SLOT_TMO]  = tmo_pend    & ier_i[EN_RX];
    req[SLOT_RDY]  = rx_ready_i  & ier_i[EN_RX];
    req[SLOT_SC]   = sc_pend     & ier_i[EN_SC];
    req[SLOT_TX]   = tx_pend     & ier_i[EN_TX];
    req[SLOT_MS]   = modem_chg_i & ier_i[EN_MS];
  end

  isr_prio_enc #(.N(NSRC)) u_enc (
    .req_i(req), .grant_o(grant), .any_o(any_req)
  );

  assign irq_o = any_req;
  assign isr_o = slot_code(grant);
endmodule

// File: rtl/isr_encoder_chk.sv
module isr_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_ready_i,
  input logic       thr_empty_i,
  input logic       line_err_evt_i,
  input logic [7:0] ier_i,
  input logic       isr_rd_i,
  input logic       thr_wr_i,
  input logic       irq_o,
  input logic [7:0] isr_o
);
  // R5
  p_irq_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !isr_o[0]);
  p_idle_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> isr_o == 8'h01);
  // R4
  p_rx_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_o == 8'h04 || isr_o == 8'h0C) |-> ier_i[0]);
  p_rdy_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    isr_o == 8'h04 |-> rx_ready_i);
  // R9
  p_sc_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    isr_o[4] |-> (ier_i[4] && isr_o[3:0] == 4'h0 && irq_o));
  // R3 / R11
  p_ls_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err_evt_i && ier_i[2]) |=> (!ier_i[2] || isr_o == 8'h06));
  // R7
  p_wr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_i && !thr_empty_i) |=> isr_o != 8'h02);
  // R6
  p_rd_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd_i && isr_o == 8'h02 && !thr_empty_i) |=> isr_o != 8'h02);
endmodule

bind isr_encoder isr_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready_i(rx_ready_i), .thr_empty_i(thr_empty_i),
  .line_err_evt_i(line_err_evt_i), .ier_i(ier_i), .isr_rd_i(isr_rd_i),
  .thr_wr_i(thr_wr_i), .irq_o(irq_o), .isr_o(isr_o)
);

// File: tb/isr_encoder_tb_top.sv
module isr_encoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_ready, tmo_evt, thr_empty, ls_evt, sc_evt, modem;
  logic [7:0] ier;
  logic       isr_rd, lsr_rd, thr_wr, rhr_rd;
  logic       irq;
  logic [7:0] isr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .rx_ready_i(rx_ready), .rx_timeout_evt_i(tmo_evt),
    .thr_empty_i(thr_empty), .line_err_evt_i(ls_evt), .spec_char_evt_i(sc_evt),
    .modem_chg_i(modem), .ier_i(ier), .isr_rd_i(isr_rd), .lsr_rd_i(lsr_rd),
    .thr_wr_i(thr_wr), .rhr_rd_i(rhr_rd), .irq_o(irq), .isr_o(isr)
  );

  // expected status from the requirement list
  function automatic logic [7:0] model(input logic ls, tmo, rdy, sc, tx, ms,
                                       input logic [7:0] en);
    if (en[2] && ls)       return 8'h06;
    else if (en[0] && tmo) return 8'h0C;
    else if (en[0] && rdy) return 8'h04;
    else if (en[4] && sc)  return 8'h10;
    else if (en[1] && tx)  return 8'h02;
    else if (en[3] && ms)  return 8'h00;
    return 8'h01;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    logic exp_irq;
    exp_irq = (exp != 8'h01);
    total++;
    if (isr !== exp || irq !== exp_irq) begin
      bad++;
      $display("FAIL %s: isr=%h irq=%b expected isr=%h irq=%b", req, isr, irq, exp, exp_irq);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic pulse_ls();  ls_evt = 1; tick(); ls_evt = 0; endtask
  task automatic pulse_tmo(); tmo_evt = 1; tick(); tmo_evt = 0; endtask
  task automatic pulse_sc();  sc_evt = 1; tick(); sc_evt = 0; endtask
  task automatic pulse_isr(); isr_rd = 1; tick(); isr_rd = 0; endtask
  task automatic pulse_lsr(); lsr_rd = 1; tick(); lsr_rd = 0; endtask
  task automatic pulse_thr(); thr_wr = 1; tick(); thr_wr = 0; endtask
  task automatic pulse_rhr(); rhr_rd = 1; tick(); rhr_rd = 0; endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: expired expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    {rx_ready, tmo_evt, thr_empty, ls_evt, sc_evt, modem} = '0;
    {isr_rd, lsr_rd, thr_wr, rhr_rd} = '0;
    ier = 8'h00;
    #3;
    do_reset();

    // R1: reset state
    check("R1 idle with enables clear", 8'h01);
    ier = 8'h02; #1;
    check("R1 tx interrupt after reset", 8'h02);

    // R2 R3 R4 R5 sweep: all pending combinations x all enable words
    for (int c = 0; c < 64; c++) begin
      ier = 8'h00;
      do_reset();
      if (!c[4]) pulse_thr();
      if (c[0]) pulse_ls();
      if (c[1]) pulse_tmo();
      if (c[3]) pulse_sc();
      rx_ready = c[2];
      modem    = c[5];
      for (int e = 0; e < 32; e++) begin
        ier = {e[2:0] ^ 3'b101, e[4:0]};
        #1;
        check("R2/R3/R4 sweep", model(c[0], c[1], c[2], c[3], c[4], c[5], ier));
      end
      rx_ready = 0;
      modem = 0;
    end

    // R6 R10: status read does not clear hidden tx
    ier = 8'h00;
    do_reset();
    ier = 8'h06;
    pulse_ls();
    check("R11 line error visible next cycle", 8'h06);
    pulse_isr();
    check("R6 status read while tx hidden", 8'h06);
    pulse_lsr();
    check("R10 tx surfaces after line read", 8'h02);
    pulse_isr();
    check("R6 status read clears reported tx", 8'h01);

    // R7: rising empty sets, write clears
    thr_empty = 1; tick();
    check("R7 rise of empty sets tx", 8'h02);
    pulse_thr();
    check("R7 write clears tx", 8'h01);
    thr_empty = 0; tick();
    thr_empty = 1; thr_wr = 1; tick(); thr_wr = 0;
    check("R7 set wins over write", 8'h02);
    thr_empty = 0;
    pulse_thr();

    // R9: special char, cleared only when reported
    ier = 8'h13;
    pulse_sc();
    check("R9 special char code", 8'h10);
    rx_ready = 1; #1;
    check("R9 rx hides special char", 8'h04);
    pulse_isr();
    rx_ready = 0; #1;
    check("R9 hidden special char kept", 8'h10);
    pulse_isr();
    check("R9 status read clears special char", 8'h01);

    // R4 R8: time-out priority and clear
    ier = 8'h01;
    pulse_tmo();
    check("R4 time-out code", 8'h0C);
    rx_ready = 1; #1;
    check("R4 time-out shown over ready", 8'h0C);
    pulse_rhr();
    check("R8 data read clears time-out", 8'h04);
    rx_ready = 0; #1;
    check("R8 idle after rx", 8'h01);
    ier = 8'h05;
    ls_evt = 1; lsr_rd = 1; tick(); ls_evt = 0; lsr_rd = 0;
    check("R8 set wins over line read", 8'h06);
    pulse_lsr();
    check("R8 line read clears error", 8'h01);

    // R2: modem level, enable gating
    modem = 1; #1;
    check("R2 modem masked", 8'h01);
    ier = 8'h08; #1;
    check("R2 modem enabled", 8'h00);
    ier = 8'hE0; #1;
    check("R2 upper enable bits ignored", 8'h01);
    modem = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule